// File: doc/BRIEF.md
# Low-power DRAM power-up sequencer

This block takes a low-power DRAM device from power-on to the point where it can accept normal traffic. After a start pulse it holds the device reset pin low for a programmable number of controller cycles. It then releases reset and waits a second programmable interval before it raises clock enable. Next it issues three mode-register writes and a two-step ZQ calibration. These go out as abstract commands on a valid/ready channel, and a separate physical layer turns them into pin activity.

The walk through the phases is fixed and never skips a phase. Every delay is counted by a single shared down-counter. The counter is reloaded when a phase is entered and after each accepted command. A command stays on the channel until the consumer takes it, and the following wait begins only after that handshake. When the latch step of calibration is accepted, the block enters its normal phase and raises a done flag. The flag stays high until a new start or a reset arrives.

Top module: `dram_pwrup_seq`

## Requirements
- R1: While `rst_n` is low and after it is released, the block shows `state_o` = 0 (idle), with `dev_rst_n_o`, `cke_o`, `cmd_valid_o` and `done_o` all low.
- R2: `state_o` uses the codes idle 0, device reset 1, power-down exit 2, mode writes 3, calibration 4, normal 5. It changes only to the next code, or from 5 back to 1.
- R3: When a start is accepted, the device reset phase lasts exactly `T_RST_LOW` cycles with `dev_rst_n_o` low. `dev_rst_n_o` rises on the following edge.
- R4: `cke_o` stays low for exactly `T_CKE_DLY` cycles after reset is released. It rises in the same cycle as the first `cmd_valid_o`, and never while `dev_rst_n_o` is low.
- R5: Three mode-register writes (`cmd_kind_o` = 0) go out in this order: register 1 = 0x14, register 2 = 0x09, register 11 = 0x00. In `cmd_arg_o`, bits 7:0 hold the value and bits ADDR_W-1:8 hold the register number, so the arguments are 0x114, 0x209 and 0xB00.
- R6: While `cmd_valid_o` is high and `cmd_ready_i` is low, the command, its kind and its argument stay unchanged.
- R7: After each mode-write handshake, `cmd_valid_o` stays low for exactly `T_MRW_GAP` cycles before the next command appears.
- R8: Calibration issues the start step (`cmd_kind_o` = 1, argument `ZQ_START_OP`, default 0x4F). After that handshake, `cmd_valid_o` stays low for exactly `T_ZQ_CAL` cycles. The latch step follows (`cmd_kind_o` = 2, argument `ZQ_LATCH_OP`, default 0x51).
- R9: `done_o` rises, with `state_o` = 5, in the cycle after the latch handshake. It stays high while no start and no reset arrive.
- R10: A start pulse in phases 1 to 4 is ignored, and the phase timing does not change.
- R11: A start pulse in the normal phase restarts the sequence. On the next edge `done_o` and `cke_o` fall, `dev_rst_n_o` goes low and `state_o` becomes 1.
- R12: While `cmd_valid_o` is low, `cmd_kind_o` and `cmd_arg_o` are zero.
- R13: With `cmd_ready_i` held high, `done_o` rises exactly T_RST_LOW + T_CKE_DLY + 3·(1+T_MRW_GAP) + (1+T_ZQ_CAL) + 1 cycles after the first device-reset cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle request to run the power-up sequence |
| cmd_ready_i | input | 1 | Consumer accepts the offered command |
| dev_rst_n_o | output | 1 | Device reset pin, active low |
| cke_o | output | 1 | Device clock enable |
| cmd_valid_o | output | 1 | A command is offered |
| cmd_kind_o | output | 2 | 0 mode write, 1 calibration start, 2 calibration latch |
| cmd_arg_o | output | ADDR_W | Packed register/value, or calibration operand |
| state_o | output | 3 | Current phase code |
| done_o | output | 1 | Sequence complete, normal operation |

## Verification
Two things can land on the same edge: a start pulse and a running delay count. If the start were taken, it would reload the shared counter. The bench pulses start in the first cycle of a mode-write gap. It then checks that the gap still spans exactly `T_MRW_GAP` cycles and that the next write carries the expected argument. The other collision is a command becoming valid while ready is already high, so the handshake happens in the command's first cycle. A run with ready tied high checks this against the closed-form total latency of R13.

// File: rtl/dram_pwrup_pkg.sv
package dram_pwrup_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_RESET  = 3'd1,
        ST_EXITPD = 3'd2,
        ST_MRW    = 3'd3,
        ST_ZQC    = 3'd4,
        ST_NORMAL = 3'd5
    } seq_state_e;

    typedef enum logic [1:0] {
        CK_MRW      = 2'd0,
        CK_ZQ_START = 2'd1,
        CK_ZQ_LATCH = 2'd2
    } cmd_kind_e;

    localparam int NUM_MRW = 3;

    // hold = command accepted, waiting out the delay that follows it
    typedef struct packed {
        seq_state_e  state;
        logic        hold;
        logic [1:0]  idx;
    } seq_regs_t;

endpackage

// File: rtl/dram_pwrup_timer.sv
module dram_pwrup_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic             zero_o
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i)
            cnt_d = load_val_i;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/dram_pwrup_mrtab.sv
module dram_pwrup_mrtab #(
    parameter int ADDR_W = 14
) (
    input  logic [1:0]        idx_i,
    output logic [ADDR_W-1:0] arg_o
);
    localparam int VAL_W = 8;

    function automatic logic [ADDR_W-1:0] pack_mr(input int unsigned regno, input int unsigned val);
        pack_mr = ADDR_W'((regno << VAL_W) | (val & 32'hFF));
    endfunction

    always_comb begin
        case (idx_i)
            2'd0:    arg_o = pack_mr(1, 32'h14);
            2'd1:    arg_o = pack_mr(2, 32'h09);
            2'd2:    arg_o = pack_mr(11, 32'h00);
            default: arg_o = '0;
        endcase
    end
endmodule

// File: rtl/dram_pwrup_seq.sv
module dram_pwrup_seq
    import dram_pwrup_pkg::*;
#(
    parameter int          ADDR_W      = 14,
    parameter int          T_RST_LOW   = 20,
    parameter int          T_CKE_DLY   = 10,
    parameter int          T_MRW_GAP   = 4,
    parameter int          T_ZQ_CAL    = 16,
    parameter logic [7:0]  ZQ_START_OP = 8'h4F,
    parameter logic [7:0]  ZQ_LATCH_OP = 8'h51
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              cmd_ready_i,
    output logic              dev_rst_n_o,
    output logic              cke_o,
    output logic              cmd_valid_o,
    output logic [1:0]        cmd_kind_o,
    output logic [ADDR_W-1:0] cmd_arg_o,
    output logic [2:0]        state_o,
    output logic              done_o
);
    localparam int T_MAX_A = (T_RST_LOW > T_CKE_DLY) ? T_RST_LOW : T_CKE_DLY;
    localparam int T_MAX_B = (T_MRW_GAP > T_ZQ_CAL) ? T_MRW_GAP : T_ZQ_CAL;
    localparam int T_MAX   = (T_MAX_A > T_MAX_B) ? T_MAX_A : T_MAX_B;
    localparam int CNT_W   = $clog2(T_MAX + 1);
    localparam logic [CNT_W-1:0] LD_RST = CNT_W'(T_RST_LOW - 1);
    localparam logic [CNT_W-1:0] LD_CKE = CNT_W'(T_CKE_DLY - 1);
    localparam logic [CNT_W-1:0] LD_GAP = CNT_W'(T_MRW_GAP - 1);
    localparam logic [CNT_W-1:0] LD_ZQ  = CNT_W'(T_ZQ_CAL - 1);
    localparam logic [1:0]       LAST_MR = 2'(NUM_MRW - 1);

    seq_regs_t          regs_d, regs_q;
    logic               tmr_load;
    logic [CNT_W-1:0]   tmr_val;
    logic               tmr_zero;
    logic [ADDR_W-1:0]  mr_arg;
    logic               offer;

    dram_pwrup_timer #(.CNT_W(CNT_W)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .zero_o     (tmr_zero)
    );

    dram_pwrup_mrtab #(.ADDR_W(ADDR_W)) u_mrtab (
        .idx_i (regs_q.idx),
        .arg_o (mr_arg)
    );

    assign offer = ((regs_q.state == ST_MRW) || (regs_q.state == ST_ZQC)) && !regs_q.hold;

    always_comb begin
        regs_d   = regs_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        case (regs_q.state)
            ST_IDLE, ST_NORMAL: begin
                if (start_i) begin
                    regs_d.state = ST_RESET;
                    regs_d.hold  = 1'b0;
                    regs_d.idx   = '0;
                    tmr_load     = 1'b1;
                    tmr_val      = LD_RST;
                end
            end
            ST_RESET: begin
                if (tmr_zero) begin
                    regs_d.state = ST_EXITPD;
                    tmr_load     = 1'b1;
                    tmr_val      = LD_CKE;
                end
            end
            ST_EXITPD: begin
                if (tmr_zero) begin
                    regs_d.state = ST_MRW;
                    regs_d.hold  = 1'b0;
                    regs_d.idx   = '0;
                end
            end
            ST_MRW: begin
                if (!regs_q.hold) begin
                    if (cmd_ready_i) begin
                        regs_d.hold = 1'b1;
                        tmr_load    = 1'b1;
                        tmr_val     = LD_GAP;
                    end
                end else if (tmr_zero) begin
                    regs_d.hold = 1'b0;
                    if (regs_q.idx == LAST_MR) begin
                        regs_d.state = ST_ZQC;
                        regs_d.idx   = '0;
                    end else begin
                        regs_d.idx = regs_q.idx + 2'd1;
                    end
                end
            end
            ST_ZQC: begin
                if (!regs_q.hold) begin
                    if (cmd_ready_i) begin
                        if (regs_q.idx == 2'd0) begin
                            regs_d.hold = 1'b1;
                            tmr_load    = 1'b1;
                            tmr_val     = LD_ZQ;
                        end else begin
                            regs_d.state = ST_NORMAL;
                            regs_d.idx   = '0;
                        end
                    end
                end else if (tmr_zero) begin
                    regs_d.hold = 1'b0;
                    regs_d.idx  = 2'd1;
                end
            end
            default: regs_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q.state <= ST_IDLE;
            regs_q.hold  <= 1'b0;
            regs_q.idx   <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    always_comb begin
        cmd_kind_o = CK_MRW;
        cmd_arg_o  = '0;
        if (offer) begin
            if (regs_q.state == ST_MRW) begin
                cmd_arg_o = mr_arg;
            end else if (regs_q.idx == 2'd0) begin
                cmd_kind_o = CK_ZQ_START;
                cmd_arg_o  = ADDR_W'(ZQ_START_OP);
            end else begin
                cmd_kind_o = CK_ZQ_LATCH;
                cmd_arg_o  = ADDR_W'(ZQ_LATCH_OP);
            end
        end
    end

    assign cmd_valid_o = offer;
    assign dev_rst_n_o = (regs_q.state != ST_IDLE) && (regs_q.state != ST_RESET);
    assign cke_o       = (regs_q.state == ST_MRW) || (regs_q.state == ST_ZQC) ||
                         (regs_q.state == ST_NORMAL);
    assign done_o      = (regs_q.state == ST_NORMAL);
    assign state_o     = regs_q.state;
endmodule

// File: rtl/dram_pwrup_seq_chk.sv
module dram_pwrup_seq_chk
    import dram_pwrup_pkg::*;
#(
    parameter int ADDR_W    = 14,
    parameter int T_RST_LOW = 20,
    parameter int T_CKE_DLY = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              cmd_ready_i,
    input logic              dev_rst_n_o,
    input logic              cke_o,
    input logic              cmd_valid_o,
    input logic [1:0]        cmd_kind_o,
    input logic [ADDR_W-1:0] cmd_arg_o,
    input logic [2:0]        state_o,
    input logic              done_o
);
    logic [15:0] rst_run_q, cke_run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rst_run_q <= '0;
            cke_run_q <= '0;
        end else begin
            rst_run_q <= (state_o == ST_RESET)  ? rst_run_q + 16'd1 : 16'd0;
            cke_run_q <= (state_o == ST_EXITPD) ? cke_run_q + 16'd1 : 16'd0;
        end
    end

    assert_state_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o != $past(state_o)) |->
            ((state_o == $past(state_o) + 3'd1) ||
             ($past(state_o) == ST_NORMAL && state_o == ST_RESET)));

    assert_rst_low_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_o) == ST_RESET && state_o == ST_EXITPD) |->
            ($past(rst_run_q) == 16'(T_RST_LOW - 1)));

    assert_cke_delay_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_o) == ST_EXITPD && state_o == ST_MRW) |->
            ($past(cke_run_q) == 16'(T_CKE_DLY - 1)));

    assert_cke_after_reset_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cke_o) |-> ($past(dev_rst_n_o) && cmd_valid_o));

    assert_hold_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_o && !cmd_ready_i) |=>
            (cmd_valid_o && $stable(cmd_kind_o) && $stable(cmd_arg_o)));

    assert_done_pins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (cke_o && dev_rst_n_o && !cmd_valid_o));

    assert_busy_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && state_o != ST_IDLE && state_o != ST_NORMAL) |=>
            (state_o != ST_RESET || $past(state_o) == ST_RESET));
endmodule

bind dram_pwrup_seq dram_pwrup_seq_chk #(
    .ADDR_W    (ADDR_W),
    .T_RST_LOW (T_RST_LOW),
    .T_CKE_DLY (T_CKE_DLY)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .cmd_ready_i (cmd_ready_i),
    .dev_rst_n_o (dev_rst_n_o),
    .cke_o       (cke_o),
    .cmd_valid_o (cmd_valid_o),
    .cmd_kind_o  (cmd_kind_o),
    .cmd_arg_o   (cmd_arg_o),
    .state_o     (state_o),
    .done_o      (done_o)
);

// File: tb/dram_pwrup_seq_bench.sv
`timescale 1ns/1ps
module dram_pwrup_seq_bench;
    localparam int ADDR_W = 14;
    localparam int T1  = 5;
    localparam int T3  = 4;
    localparam int GAP = 3;
    localparam int ZQ  = 6;
    localparam int TOTAL = T1 + T3 + 3 * (1 + GAP) + (1 + ZQ) + 1;

    // command stream: kind, argument, cycles ready is held back, expected quiet gap
    localparam int N_CMD = 5;
    localparam int EXP_KIND [N_CMD] = '{0, 0, 0, 1, 2};
    localparam int EXP_ARG  [N_CMD] = '{32'h114, 32'h209, 32'hB00, 32'h4F, 32'h51};
    localparam int HOLD     [N_CMD] = '{0, 2, 1, 3, 0};
    localparam int EXP_GAP  [N_CMD] = '{GAP, GAP, GAP, ZQ, 0};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic cmd_ready_i = 1'b0;
    logic dev_rst_n_o, cke_o, cmd_valid_o, done_o;
    logic [1:0] cmd_kind_o;
    logic [ADDR_W-1:0] cmd_arg_o;
    logic [2:0] state_o;

    int n_tests = 0;
    int n_fail  = 0;

    always #2.5 clk = ~clk;

    dram_pwrup_seq #(
        .ADDR_W(ADDR_W), .T_RST_LOW(T1), .T_CKE_DLY(T3),
        .T_MRW_GAP(GAP), .T_ZQ_CAL(ZQ)
    ) u_dram_pwrup_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .cmd_ready_i(cmd_ready_i),
        .dev_rst_n_o(dev_rst_n_o), .cke_o(cke_o), .cmd_valid_o(cmd_valid_o),
        .cmd_kind_o(cmd_kind_o), .cmd_arg_o(cmd_arg_o), .state_o(state_o),
        .done_o(done_o)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    task automatic pulse_start();
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic check_idle(input string tag);
        chk(state_o == 3'd0, {tag, " state"}, int'(state_o), 0);
        chk(!dev_rst_n_o && !cke_o && !cmd_valid_o && !done_o, {tag, " pins"},
            int'({dev_rst_n_o, cke_o, cmd_valid_o, done_o}), 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL R2 watchdog expired actual=%0d expected=%0d", 20000, TOTAL);
        finish_run();
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        check_idle("R1 in reset");
        rst_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check_idle("R1 after reset");

        // first run: stall the consumer per table
        pulse_start();
        chk(state_o == 3'd1, "R2 reset phase code", int'(state_o), 1);
        n = 0;
        while (!dev_rst_n_o && n < 100) begin n++; @(negedge clk); end
        chk(n == T1, "R3 reset-low length", n, T1);
        chk(state_o == 3'd2, "R2 exit phase code", int'(state_o), 2);
        n = 0;
        while (!cke_o && n < 100) begin n++; @(negedge clk); end
        chk(n == T3, "R4 cke delay", n, T3);
        chk(cmd_valid_o, "R4 cke with first command", int'(cmd_valid_o), 1);

        for (int i = 0; i < N_CMD; i++) begin
            int g;
            chk(cmd_valid_o && int'(cmd_kind_o) == EXP_KIND[i],
                (i < 3) ? "R5 kind" : "R8 kind", int'(cmd_kind_o), EXP_KIND[i]);
            chk(int'(cmd_arg_o) == EXP_ARG[i],
                (i < 3) ? "R5 argument" : "R8 operand", int'(cmd_arg_o), EXP_ARG[i]);
            chk(int'(state_o) == ((i < 3) ? 3 : 4), "R2 command phase",
                int'(state_o), (i < 3) ? 3 : 4);
            for (int h = 0; h < HOLD[i]; h++) begin
                @(negedge clk);
                chk(cmd_valid_o && int'(cmd_arg_o) == EXP_ARG[i] &&
                    int'(cmd_kind_o) == EXP_KIND[i], "R6 held command",
                    int'(cmd_arg_o), EXP_ARG[i]);
            end
            cmd_ready_i = 1'b1;
            @(negedge clk);
            cmd_ready_i = 1'b0;
            g = 0;
            while (!cmd_valid_o && !done_o && g < 100) begin
                if (g == 1)
                    chk(cmd_kind_o == 2'd0 && cmd_arg_o == '0, "R12 idle channel",
                        int'(cmd_arg_o), 0);
                start_i = (i == 1 && g == 0);
                g++;
                @(negedge clk);
            end
            start_i = 1'b0;
            chk(g == EXP_GAP[i], (i == 3) ? "R8 calibration wait" :
                (i == 1) ? "R10 gap with busy start" : "R7 write gap", g, EXP_GAP[i]);
        end
        chk(done_o && state_o == 3'd5, "R9 done after latch", int'(state_o), 5);
        repeat (5) @(negedge clk);
        chk(done_o && cke_o && dev_rst_n_o, "R9 done stays", int'(done_o), 1);

        // restart from normal, ready tied high
        cmd_ready_i = 1'b1;
        pulse_start();
        chk(state_o == 3'd1, "R11 restart phase", int'(state_o), 1);
        chk(!done_o && !cke_o && !dev_rst_n_o, "R11 restart pins",
            int'({done_o, cke_o, dev_rst_n_o}), 0);
        n = 0;
        while (!done_o && n < 200) begin n++; @(negedge clk); end
        chk(n == TOTAL, "R13 total latency", n, TOTAL);

        // reset in the middle of a run
        pulse_start();
        repeat (T1 + T3 + 1) @(negedge clk);
        chk(cke_o, "R4 cke up before mid-run reset", int'(cke_o), 1);
        rst_n = 1'b0;
        @(negedge clk);
        check_idle("R1 mid-run reset");
        rst_n = 1'b1;
        cmd_ready_i = 1'b0;
        pulse_start();
        pulse_start();
        chk(state_o == 3'd1 && !dev_rst_n_o, "R10 second start in reset phase",
            int'(state_o), 1);
        n = 1;
        while (!dev_rst_n_o && n < 100) begin n++; @(negedge clk); end
        chk(n == T1, "R3 reset-low length with extra start", n, T1);

        finish_run();
    end
endmodule